// File: doc/BRIEF.md
# Column Supply Rail Selector

This block decides, for every physical column of an SRAM array, whether that column's cells are powered from the high supply rail or the low supply rail. The choice follows the array's operation mode. In standby every column sits on the low rail to cut leakage. During a read every column is raised so that the cells on the active wordline hold their state. During a write, only the columns actually being written stay low, which makes them easy to overwrite. All other columns are raised so that the half-selected cells in a multiplexed word are shielded from disturb.

Columns are multiplexed eight to one. Each word group holds eight adjacent physical columns, and a shared column address picks one column in every group. A per-word write enable decides which groups are really written in a given access. The mode, address and enables are presented one cycle ahead of the access. The per-column select vector is registered, so it is settled before the wordline rises. The analog switches that the vector drives are outside this block.

Top module: `csel_rail_select`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every select bit is 0 (low rail). A select bit of 1 means the high rail.
- R2: Mode code 2'b00 (standby) drives every select bit to 0.
- R3: Mode code 2'b01 (read) drives every select bit to 1.
- R4: Mode code 2'b10 (write) drives column index g*8+a to 0 for each word group g whose write-enable bit g is 1, where a is the column address.
- R5: In write mode, every column not named by R4 is 1. This covers the other seven columns of an enabled group and all columns of a disabled group. With no write enable set, every column is 1.
- R6: Mode code 2'b11 (undefined) drives every select bit to 1 as a safe state.
- R7: Outside write mode, the column address and write enables have no effect on the select vector.
- R8: The select vector changes only at a rising clock edge and reflects the inputs sampled at that edge. Input changes between edges do not reach the output early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operation mode: 00 standby, 01 read, 10 write, 11 undefined |
| col_addr_i | input | 3 | Column address within each word group |
| word_we_i | input | 4 | Write enable, one bit per word group |
| rail_sel_o | output | 32 | Per-column supply select, 1 = high rail, 0 = low rail |

## Verification
The two functions that meet in one cycle are lowering the written column and raising its seven neighbours in the same group. Both happen in a single write, while disabled groups are raised at the same edge. The bench provokes this by sweeping every column address against enable patterns that mix enabled and disabled groups, including all and none. It judges each resulting vector bit by bit against a model that computes each column's rail from its own group and offset. It also feeds changing addresses and enables during reads, standby and the undefined code, to show they leave the vector untouched.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        CS_STANDBY = 2'b00,
        CS_READ    = 2'b01,
        CS_WRITE   = 2'b10,
        CS_UNDEF   = 2'b11
    } csel_mode_e;

endpackage

// File: rtl/csel_addr_dec.sv
module csel_addr_dec #(
    parameter int MUX    = 8,
    localparam int ADDR_W = (MUX > 1) ? $clog2(MUX) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MUX-1:0]    onehot_o
);

    always_comb begin
        onehot_o = '0;
        for (int i = 0; i < MUX; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                onehot_o[i] = 1'b1;
            end
        end
    end

    always_comb begin
        assert_dec_onehot_R4: assert ($countones(onehot_o) <= 1)
            else $error("column decode not one-hot");
    end

endmodule

// File: rtl/csel_group.sv
module csel_group
    import csel_pkg::*;
#(
    parameter int MUX = 8
) (
    input  logic [1:0]     mode_i,
    input  logic [MUX-1:0] col_hot_i,
    input  logic           we_i,
    output logic [MUX-1:0] rail_o
);

    csel_mode_e mode;

    always_comb begin
        mode = csel_mode_e'(mode_i);
        unique case (mode)
            CS_STANDBY: rail_o = '0;
            CS_READ:    rail_o = '1;
            CS_WRITE:   rail_o = we_i ? ~col_hot_i : '1;
            default:    rail_o = '1;
        endcase
    end

    always_comb begin
        if (mode_i == 2'b10) begin
            assert_group_low_le1_R5: assert ($countones(~rail_o) <= 1)
                else $error("more than one low column in a written group");
        end
    end

endmodule

// File: rtl/csel_rail_select.sv
module csel_rail_select
    import csel_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int MUX   = 8,
    localparam int COLS   = WORDS * MUX,
    localparam int ADDR_W = (MUX > 1) ? $clog2(MUX) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] col_addr_i,
    input  logic [WORDS-1:0]  word_we_i,
    output logic [COLS-1:0]   rail_sel_o
);

    typedef struct packed {
        logic [COLS-1:0] rail;
    } state_t;

    state_t state_d, state_q;

    logic [MUX-1:0]  col_hot;
    logic [COLS-1:0] rail_comb;

    csel_addr_dec #(.MUX(MUX)) u_dec (
        .addr_i   (col_addr_i),
        .onehot_o (col_hot)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_grp
        csel_group #(.MUX(MUX)) u_grp (
            .mode_i    (mode_i),
            .col_hot_i (col_hot),
            .we_i      (word_we_i[g]),
            .rail_o    (rail_comb[g*MUX +: MUX])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.rail = rail_comb;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rail_sel_o = state_q.rail;

    assert_standby_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b00) |=> (rail_sel_o == '0))
        else $error("standby did not lower every column");

    assert_read_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b01) |=> (rail_sel_o == '1))
        else $error("read did not raise every column");

    assert_write_lowcount_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b10) |=> ($countones(~rail_sel_o) == $countones($past(word_we_i))))
        else $error("low column count differs from enabled groups");

    assert_write_none_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b10 && word_we_i == '0) |=> (rail_sel_o == '1))
        else $error("write with no enables left a column low");

    assert_undef_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'b11) |=> (rail_sel_o == '1))
        else $error("undefined mode did not raise every column");

    assert_reset_low_R1: assert property (@(posedge clk_i)
        (!rst_ni) |=> (rail_sel_o == '0))
        else $error("reset did not clear the select vector");

endmodule

// File: tb/tb_csel_rail_select.sv
module tb_csel_rail_select;

    localparam int WORDS = 4;
    localparam int MUX   = 8;
    localparam int COLS  = WORDS * MUX;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [2:0]       addr = '0;
    logic [WORDS-1:0] we = '0;
    logic [COLS-1:0]  sel;

    int checks = 0;
    int errors = 0;

    logic [COLS-1:0] exp_q[$];
    string           tag_q[$];
    logic [COLS-1:0] last_exp = '0;

    always #5 clk = ~clk;

    csel_rail_select #(.WORDS(WORDS), .MUX(MUX)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (mode),
        .col_addr_i (addr),
        .word_we_i  (we),
        .rail_sel_o (sel)
    );

    function automatic logic [COLS-1:0] model(input logic [1:0] m, input logic [2:0] a,
                                              input logic [WORDS-1:0] w);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) begin
            int grp = c / MUX;
            int off = c % MUX;
            case (m)
                2'b00:   v[c] = 1'b0;
                2'b10:   v[c] = (w[grp] && off == int'(a)) ? 1'b0 : 1'b1;
                default: v[c] = 1'b1;
            endcase
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] m, input logic [2:0] a,
                         input logic [WORDS-1:0] w);
        @(negedge clk);
        mode = m;
        addr = a;
        we   = w;
        exp_q.push_back(model(m, a, w));
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), sel, last_exp);
            end
        end
    end

    initial begin : watchdog
        #500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        // R1: reset state, with inputs that would otherwise raise columns
        mode = 2'b01;
        we   = '1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 during reset", sel, '0);
        @(negedge clk);
        mode  = 2'b00;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 first cycle after reset", sel, '0);

        drive("R3 read", 2'b01, 3'd0, '0);
        drive("R2 standby", 2'b00, 3'd5, '1);
        drive("R6 undefined code", 2'b11, 3'd2, 4'b0101);

        // R4 and R5: sweep every address with mixed enable patterns
        for (int a = 0; a < MUX; a++) begin
            drive("R4 write single group", 2'b10, 3'(a), 4'b0001 << (a % WORDS));
            drive("R4 write all groups", 2'b10, 3'(a), 4'b1111);
            drive("R5 write mixed groups", 2'b10, 3'(a), 4'b1010);
        end
        drive("R5 write no enables", 2'b10, 3'd6, 4'b0000);
        drive("R4 write last column", 2'b10, 3'd7, 4'b1000);

        // R7: address and enables vary outside write mode
        drive("R7 read ignores addr/we", 2'b01, 3'd3, 4'b1111);
        drive("R7 read ignores addr/we", 2'b01, 3'd7, 4'b0110);
        drive("R7 standby ignores addr/we", 2'b00, 3'd1, 4'b1111);
        drive("R7 standby ignores addr/we", 2'b00, 3'd4, 4'b1001);
        drive("R7 undefined ignores addr/we", 2'b11, 3'd0, 4'b1111);

        // R8: mid-cycle change must not reach the output before the edge
        drive("R8 setup write", 2'b10, 3'd2, 4'b0011);
        @(negedge clk);
        mode = 2'b00;
        addr = 3'd5;
        we   = '0;
        #1;
        check("R8 no early update", sel, model(2'b10, 3'd2, 4'b0011));
        exp_q.push_back(model(2'b00, 3'd5, '0));
        tag_q.push_back("R8 update at edge");

        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule